// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block sequences a successive-approximation converter through a start/done handshake. It holds two independent groups of channel ranks. The regular group has up to sixteen ranks and the injected group has up to four. Each group can be started by a software start request or by an external trigger pulse. For every rank, the block issues a one-cycle start strobe with the channel number of that rank. It then waits for the converter's done pulse and stores the returned 16-bit sample.

Regular samples overwrite a single regular result register. Injected samples go to one of four slots chosen by rank. Four sticky status flags mark the end of each conversion and the end of each sequence, per group. Each flag has its own interrupt enable, and the interrupt line is their masked OR. The regular group can run in continuous mode, in which it wraps back to its first rank without a new trigger. A pending injected sequence takes the converter at the next conversion boundary, and the regular sequence then resumes where it left off.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `cont_mode` low, a started group converts each of its ranks once, then its busy output falls and no further `conv_start` is issued for it.
- R2: A regular sequence starts on `reg_start_set` or `reg_trig`, and an injected sequence starts on `inj_start_set` or `inj_trig`. The group's busy output rises the cycle after the request, and `conv_start` follows one cycle later when the converter is free.
- R3: Each completed regular conversion loads `conv_data` into `reg_data` and sets flag bit 0 (regular end of conversion).
- R4: Each completed injected conversion of rank k (0..3) loads `conv_data` into `inj_data[16k+15:16k]` and sets flag bit 2 (injected end of conversion).
- R5: Completion of the last rank of a group sets its end-of-sequence flag: bit 1 for regular, bit 3 for injected. The group's next sequence starts at rank 0.
- R6: With `cont_mode` high, the regular group restarts at rank 0 after its last rank with no new request, and `reg_busy` stays high.
- R7: When the converter is free and both groups are active, the injected rank is converted first. The regular group then continues from the rank after the last one it completed.
- R8: Flags are sticky. A flag clears only when the matching bit of `flag_clr` is 1. A set and a clear in the same cycle leave the flag set. All flags are 0 after reset.
- R9: `irq` equals the OR over bits of `flags & irq_en`.
- R10: The channel of regular rank k is `reg_chan_list[5k+4:5k]`, and the channel of injected rank k is `inj_chan_list[5k+4:5k]`. A sequence has length field+1, so a length field of 0 converts a single channel.
- R11: A start request for a group that is already active has no effect on that group's rank order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cont_mode | input | 1 | Regular group continuous mode |
| reg_start_set | input | 1 | Software regular start request (pulse) |
| reg_trig | input | 1 | External regular trigger pulse |
| reg_len_m1 | input | 4 | Regular sequence length minus one |
| reg_chan_list | input | 80 | Regular rank channels, 5 bits per rank |
| inj_start_set | input | 1 | Software injected start request (pulse) |
| inj_trig | input | 1 | External injected trigger pulse |
| inj_len_m1 | input | 2 | Injected sequence length minus one |
| inj_chan_list | input | 20 | Injected rank channels, 5 bits per rank |
| flag_clr | input | 4 | Write-1-to-clear strobes for flags |
| irq_en | input | 4 | Per-flag interrupt enables |
| conv_start | output | 1 | Converter start strobe |
| conv_chan | output | 5 | Channel for the started conversion |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 16 | Converter result, valid with conv_done |
| reg_data | output | 16 | Last regular result |
| inj_data | output | 64 | Four injected result slots |
| flags | output | 4 | Status flags {inj eos, inj eoc, reg eos, reg eoc} |
| irq | output | 1 | Interrupt |
| reg_busy | output | 1 | Regular start bit readback (group active) |
| inj_busy | output | 1 | Injected start bit readback (group active) |

## Verification
The bench aims an injected trigger at a continuous regular run and at a regular sequence in mid-flight. A design that restarted the regular ranks or dropped one after the interruption would show the wrong channel on the next start. It re-requests an already running group, which would reset the rank order in a design that treated the request as a restart. It also sets and clears flags in the same cycle, runs single-rank sequences and switches continuous mode off mid-run. A design that let the clear win, mishandled length 1, or kept restarting after the switch would then diverge from the model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FLAG_W      = 4;
  localparam int FL_REG_EOC  = 0;
  localparam int FL_REG_EOS  = 1;
  localparam int FL_INJ_EOC  = 2;
  localparam int FL_INJ_EOS  = 3;
  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/adc_seq_group.sv
module adc_seq_group #(
  parameter int RANK_W = 4,
  parameter int CH_W   = 5,
  localparam int DEPTH = 1 << RANK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  cont,
  input  logic [RANK_W-1:0]     len_m1,
  input  logic [DEPTH*CH_W-1:0] chan_list,
  input  logic                  done,
  output logic                  act,
  output logic [RANK_W-1:0]     rank,
  output logic [CH_W-1:0]       chan,
  output logic                  last
);
  logic              act_q, act_d;
  logic [RANK_W-1:0] rank_q, rank_d;

  assign last = (rank_q >= len_m1);
  assign chan = chan_list[rank_q*CH_W +: CH_W];
  assign act  = act_q;
  assign rank = rank_q;

  always_comb begin
    act_d  = act_q;
    rank_d = rank_q;
    if (done) begin
      if (last) begin
        rank_d = '0;
        if (!cont) act_d = 1'b0;
      end else begin
        rank_d = rank_q + 1'b1;
      end
    end
    if (req) act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rank_q <= '0;
    end else begin
      act_q <= act_d;
      if (done) rank_q <= rank_d;
    end
  end

  p_cont_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && act_q) |=> act_q);
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && last) |=> (rank_q == '0));
  p_req_keeps_rank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && act_q && !done) |=> (act_q && $stable(rank_q)));
endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags
  import adc_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set,
  input  flag_vec_t clr,
  input  flag_vec_t ien,
  output flag_vec_t flags,
  output logic      irq
);
  flag_vec_t fl_q, fl_d;

  always_comb fl_d = (fl_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign flags = fl_q;
  assign irq   = |(fl_q & ien);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fl_q & $past(fl_q & ~clr)) == $past(fl_q & ~clr)));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((fl_q & $past(set)) == $past(set)));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W       = 5,
  parameter int DATA_W     = 16,
  parameter int REG_RANK_W = 4,
  parameter int INJ_RANK_W = 2,
  localparam int REG_DEPTH = 1 << REG_RANK_W,
  localparam int INJ_DEPTH = 1 << INJ_RANK_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cont_mode,
  input  logic                       reg_start_set,
  input  logic                       reg_trig,
  input  logic [REG_RANK_W-1:0]      reg_len_m1,
  input  logic [REG_DEPTH*CH_W-1:0]  reg_chan_list,
  input  logic                       inj_start_set,
  input  logic                       inj_trig,
  input  logic [INJ_RANK_W-1:0]      inj_len_m1,
  input  logic [INJ_DEPTH*CH_W-1:0]  inj_chan_list,
  input  logic [FLAG_W-1:0]          flag_clr,
  input  logic [FLAG_W-1:0]          irq_en,
  output logic                       conv_start,
  output logic [CH_W-1:0]            conv_chan,
  input  logic                       conv_done,
  input  logic [DATA_W-1:0]          conv_data,
  output logic [DATA_W-1:0]          reg_data,
  output logic [INJ_DEPTH*DATA_W-1:0] inj_data,
  output logic [FLAG_W-1:0]          flags,
  output logic                       irq,
  output logic                       reg_busy,
  output logic                       inj_busy
);
  logic                  reg_act, inj_act, reg_last, inj_last;
  logic [REG_RANK_W-1:0] reg_rank;
  logic [INJ_RANK_W-1:0] inj_rank;
  logic [CH_W-1:0]       reg_ch, inj_ch;
  logic                  reg_req, inj_req;

  logic                  busy_q, busy_d;
  logic                  cur_inj_q, cur_inj_d;
  logic                  start_q, start_d;
  logic [CH_W-1:0]       chan_q, chan_d;
  logic                  issue, fin, reg_done, inj_done;
  flag_vec_t             fl_set;
  logic [DATA_W-1:0]     rdata_q;
  logic [DATA_W-1:0]     idata_q [INJ_DEPTH];

  assign reg_req  = reg_start_set | reg_trig;
  assign inj_req  = inj_start_set | inj_trig;
  assign fin      = busy_q & conv_done;
  assign reg_done = fin & ~cur_inj_q;
  assign inj_done = fin &  cur_inj_q;
  assign issue    = ~busy_q & (reg_act | inj_act);

  adc_seq_group #(.RANK_W(REG_RANK_W), .CH_W(CH_W)) u_reg_grp (
    .clk(clk), .rst_n(rst_n), .req(reg_req), .cont(cont_mode),
    .len_m1(reg_len_m1), .chan_list(reg_chan_list), .done(reg_done),
    .act(reg_act), .rank(reg_rank), .chan(reg_ch), .last(reg_last));

  adc_seq_group #(.RANK_W(INJ_RANK_W), .CH_W(CH_W)) u_inj_grp (
    .clk(clk), .rst_n(rst_n), .req(inj_req), .cont(1'b0),
    .len_m1(inj_len_m1), .chan_list(inj_chan_list), .done(inj_done),
    .act(inj_act), .rank(inj_rank), .chan(inj_ch), .last(inj_last));

  // Arbitration: injected group wins whenever the converter is free.
  always_comb begin
    busy_d    = busy_q;
    cur_inj_d = cur_inj_q;
    chan_d    = chan_q;
    start_d   = issue;
    if (fin) busy_d = 1'b0;
    if (issue) begin
      busy_d    = 1'b1;
      cur_inj_d = inj_act;
      chan_d    = inj_act ? inj_ch : reg_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cur_inj_q <= 1'b0;
      start_q   <= 1'b0;
      chan_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      if (issue) begin
        cur_inj_q <= cur_inj_d;
        chan_q    <= chan_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (reg_done) rdata_q <= conv_data;
  end

  for (genvar k = 0; k < INJ_DEPTH; k++) begin : g_inj_slot
    logic wr_en;
    assign wr_en = inj_done && (inj_rank == INJ_RANK_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idata_q[k] <= '0;
      else if (wr_en) idata_q[k] <= conv_data;
    end
    assign inj_data[k*DATA_W +: DATA_W] = idata_q[k];
  end

  always_comb begin
    fl_set             = '0;
    fl_set[FL_REG_EOC] = reg_done;
    fl_set[FL_REG_EOS] = reg_done & reg_last;
    fl_set[FL_INJ_EOC] = inj_done;
    fl_set[FL_INJ_EOS] = inj_done & inj_last;
  end

  adc_seq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(fl_set), .clr(flag_clr),
    .ien(irq_en), .flags(flags), .irq(irq));

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign reg_data   = rdata_q;
  assign reg_busy   = reg_act;
  assign inj_busy   = inj_act;

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy_q);
  p_inj_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && inj_act) |=> (conv_start && cur_inj_q));
  p_start_needs_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !reg_act && !inj_act) |=> !conv_start);
  p_single_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_done && reg_last && !cont_mode && !reg_req) |=> !reg_act);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cont_mode = 1'b0;
  logic        reg_start_set = 1'b0, reg_trig = 1'b0;
  logic [3:0]  reg_len_m1 = '0;
  logic [79:0] reg_chan_list;
  logic        inj_start_set = 1'b0, inj_trig = 1'b0;
  logic [1:0]  inj_len_m1 = '0;
  logic [19:0] inj_chan_list;
  logic [3:0]  flag_clr = '0, irq_en = '0;
  logic        conv_start, conv_done, irq, reg_busy, inj_busy;
  logic [4:0]  conv_chan;
  logic [15:0] conv_data, reg_data;
  logic [63:0] inj_data;
  logic [3:0]  flags;

  int rl[16];
  int il[4];
  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 16; k++) reg_chan_list[k*5 +: 5] = 5'(rl[k]);
    for (int k = 0; k < 4; k++)  inj_chan_list[k*5 +: 5] = 5'(il[k]);
  end

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cont_mode(cont_mode),
    .reg_start_set(reg_start_set), .reg_trig(reg_trig),
    .reg_len_m1(reg_len_m1), .reg_chan_list(reg_chan_list),
    .inj_start_set(inj_start_set), .inj_trig(inj_trig),
    .inj_len_m1(inj_len_m1), .inj_chan_list(inj_chan_list),
    .flag_clr(flag_clr), .irq_en(irq_en),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data),
    .reg_data(reg_data), .inj_data(inj_data), .flags(flags), .irq(irq),
    .reg_busy(reg_busy), .inj_busy(inj_busy));

  // Converter stub: fixed latency, result encodes channel and a sample count.
  int         s_cnt;
  logic [4:0] s_ch;
  logic [7:0] s_num;
  assign conv_done = (s_cnt == 1);
  assign conv_data = {s_ch, 3'b101, s_num};
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cnt <= 0; s_ch <= '0; s_num <= 8'h3c;
    end else if (conv_start) begin
      s_cnt <= LAT; s_ch <= conv_chan;
    end else if (s_cnt > 0) begin
      s_cnt <= s_cnt - 1;
      if (s_cnt == 1) s_num <= s_num + 8'd7;
    end
  end

  // Behavioural reference model.
  bit          m_ra, m_ia, m_busy, m_cur, m_start, m_fin, m_issue, m_rend, m_iend;
  int          m_ri, m_ii;
  logic [4:0]  m_chan;
  logic [15:0] m_rd;
  logic [15:0] m_id[4];
  logic [3:0]  m_fl, m_set;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ra = 0; m_ia = 0; m_busy = 0; m_cur = 0; m_start = 0;
      m_ri = 0; m_ii = 0; m_chan = '0; m_rd = '0; m_fl = '0;
      for (int k = 0; k < 4; k++) m_id[k] = '0;
    end else begin
      m_fin   = m_busy && conv_done;
      m_issue = !m_busy && (m_ra || m_ia);
      m_set = '0; m_rend = 0; m_iend = 0;
      if (m_fin) begin
        m_busy = 0;
        if (m_cur) begin
          m_id[m_ii] = conv_data; m_set[2] = 1'b1;
          if (m_ii >= int'(inj_len_m1)) begin m_set[3] = 1'b1; m_iend = 1; m_ii = 0; end
          else m_ii++;
        end else begin
          m_rd = conv_data; m_set[0] = 1'b1;
          if (m_ri >= int'(reg_len_m1)) begin m_set[1] = 1'b1; m_rend = 1; m_ri = 0; end
          else m_ri++;
        end
      end
      m_start = m_issue;
      if (m_issue) begin
        m_cur  = m_ia;
        m_chan = m_ia ? 5'(il[m_ii]) : 5'(rl[m_ri]);
        m_busy = 1;
      end
      m_ia = (m_ia && !m_iend) || inj_start_set || inj_trig;
      m_ra = (m_ra && !(m_rend && !cont_mode)) || reg_start_set || reg_trig;
      m_fl = (m_fl & ~flag_clr) | m_set;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 R2 R6 R7 conv_start", 64'(conv_start), 64'(m_start));
      if (m_start) chk("R10 R11 R7 conv_chan", 64'(conv_chan), 64'(m_chan));
      chk("R3 reg_data", 64'(reg_data), 64'(m_rd));
      chk("R4 inj_data", inj_data, {m_id[3], m_id[2], m_id[1], m_id[0]});
      chk("R5 R8 flags", 64'(flags), 64'(m_fl));
      chk("R9 irq", 64'(irq), 64'(|(m_fl & irq_en)));
      chk("R1 R6 R11 reg_busy", 64'(reg_busy), 64'(m_ra));
      chk("R1 inj_busy", 64'(inj_busy), 64'(m_ia));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_reg(input bit ext);
    @(negedge clk);
    if (ext) reg_trig = 1'b1; else reg_start_set = 1'b1;
    @(negedge clk);
    reg_trig = 1'b0; reg_start_set = 1'b0;
  endtask

  task automatic pulse_inj(input bit ext);
    @(negedge clk);
    if (ext) inj_trig = 1'b1; else inj_start_set = 1'b1;
    @(negedge clk);
    inj_trig = 1'b0; inj_start_set = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((reg_busy || inj_busy || m_busy) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    tick(3);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) rl[k] = (k * 7 + 3) % 32;
    for (int k = 0; k < 4; k++)  il[k] = 20 + k * 3;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // Reset state (R8)
    chk("R8 reset flags", 64'(flags), 64'd0);
    chk("R9 reset irq", 64'(irq), 64'd0);
    chk("R1 reset busy", 64'({reg_busy, inj_busy}), 64'd0);

    // Single regular sequence of 3 via software start (R1 R2 R3 R5 R10)
    irq_en = 4'b0011; reg_len_m1 = 4'd2;
    pulse_reg(1'b0);
    wait_idle();
    chk("R1 idle after single", 64'(reg_busy), 64'd0);
    chk("R5 reg eos set", 64'(flags[1]), 64'd1);

    // Injected sequence of 4 via trigger (R4)
    inj_len_m1 = 2'd3; irq_en = 4'b1100;
    pulse_inj(1'b1);
    wait_idle();
    chk("R4 inj eos set", 64'(flags[3]), 64'd1);

    // Clear some flags, set-and-clear race (R8)
    @(negedge clk); flag_clr = 4'b0101; @(negedge clk); flag_clr = '0;
    chk("R8 partial clear", 64'(flags), 64'b1010);
    reg_len_m1 = 4'd0;
    @(negedge clk); reg_trig = 1'b1; @(negedge clk); reg_trig = 1'b0;
    while (!conv_done) @(negedge clk);
    flag_clr = 4'b1111; @(negedge clk); flag_clr = '0;
    chk("R8 set wins over clear", 64'(flags), 64'b0011);
    wait_idle();

    // Regular 5 ranks with mid-flight injection and re-request (R7 R11)
    reg_len_m1 = 4'd4; inj_len_m1 = 2'd1; irq_en = 4'b1111;
    pulse_reg(1'b1);
    tick(9);
    pulse_inj(1'b0);
    tick(4);
    pulse_reg(1'b0);
    wait_idle();

    // Simultaneous start of both groups (R7)
    reg_len_m1 = 4'd1; inj_len_m1 = 2'd0;
    @(negedge clk); reg_start_set = 1'b1; inj_trig = 1'b1;
    @(negedge clk); reg_start_set = 1'b0; inj_trig = 1'b0;
    wait_idle();

    // Continuous mode with injection, then switch off (R6)
    cont_mode = 1'b1; reg_len_m1 = 4'd2; inj_len_m1 = 2'd2;
    pulse_reg(1'b0);
    tick(60);
    chk("R6 still busy in continuous", 64'(reg_busy), 64'd1);
    pulse_inj(1'b1);
    tick(50);
    cont_mode = 1'b0;
    wait_idle();
    chk("R6 stops after cont off", 64'(reg_busy), 64'd0);

    // Full 16-rank single sequence (R10)
    reg_len_m1 = 4'd15; irq_en = 4'b0001;
    pulse_reg(1'b0);
    wait_idle();
    tick(5);
    chk("R1 no starts when idle", 64'(conv_start), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule